// File: doc/BRIEF.md
# Register Slave with Variable Read/Write Latency and Push Queue

This block is a completer on an APB bus. It holds three plain data registers, a status register and a push port into a small queue that another unit drains through a side interface. Each register answers after its own fixed number of wait states. The completer holds its ready output high while idle, so it never stalls a shared ready line. When an access is rejected, the completer ends it with an error response and commits nothing.

Readiness is taken from one registered flag, and that same flag gates the read data. Write commits and error responses are allowed only in the cycle where select, enable and ready are all high. A wait cycle can therefore never complete an access or commit one early. The word address and the privilege bit are captured in the setup cycle and used for the rest of the access.

The controller has three named states:
- `ST_IDLE`: ready is high. A setup cycle moves it to `ST_DONE` when the access has zero wait states, and to `ST_WAIT` otherwise.
- `ST_WAIT`: ready is low and a counter runs down. When the counter reaches its last count the controller moves to `ST_DONE`. If select is dropped, the controller returns to `ST_IDLE`.
- `ST_DONE`: ready and the data-valid flag are high. The controller always returns to `ST_IDLE` after one cycle.

Top module: `apbw_slave`

## Requirements
- R1: Out of reset, and in any cycle after one in which select was low, `pready` is 1. Out of reset, `pslverr` is 0, `prdata` is 0 and `drain_valid` is 0.
- R2: The register index is `paddr[7:2]`, and `paddr[1:0]` is ignored. The number of wait states per index applies to reads and writes alike: index 0 takes 0, index 1 takes 1, index 2 takes 2, index 3 takes 3 and index 4 takes 1. An access rejected by decode or by the privilege check takes 0 wait states.
- R3: `prdata` is 0 in every cycle except the completing cycle of a read. A read error returns 0.
- R4: A write takes effect only in its completing cycle. An access whose select is dropped during a wait cycle changes nothing.
- R5: Indices 5 and above are unmapped. An access to them ends with `pslverr`=1 and has no effect.
- R6: Indices 2 and 3 need `pprot[0]`=1. Without it, the access ends with `pslverr`=1 and has no effect. Checks run in a fixed order: decode, then privilege, then queue overflow. An unprivileged push into a full queue is therefore a privilege error and does not set the overflow flag.
- R7: A privileged write to index 3 appends `pwdata` to the queue. A read of index 3 returns the number of entries held. `drain_valid` is high while the queue is not empty, and `drain_data` shows the oldest entry. A `drain_pop` pulse removes that entry, and entries leave in the order they were pushed.
- R8: A push while the queue already holds 4 entries ends with `pslverr`=1, drops the data and sets the sticky overflow flag.
- R9: A read of index 4 returns the overflow flag in bit 0 and the queue count in bits 15:8. A write to index 4 with `pwdata[0]`=1 clears the flag, and one with `pwdata[0]`=0 leaves it unchanged.
- R10: `pslverr` is 1 only in a completing cycle, where `psel`, `penable` and `pready` are all 1.
- R11: Indices 0, 1 and 2 reset to 0 and read back the last value written to them by an accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Completer select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | DATA_W | Write data |
| pprot | input | 3 | Protection attributes; bit 0 marks a privileged access |
| prdata | output | DATA_W | Read data, valid in the completing cycle |
| pready | output | 1 | Registered ready |
| pslverr | output | 1 | Error response |
| drain_pop | input | 1 | Removes the oldest queue entry |
| drain_valid | output | 1 | Queue holds at least one entry |
| drain_data | output | DATA_W | Oldest queue entry |

## Verification
Random traffic covers every index, including unmapped ones, with both directions and random privilege bits. Drain pulses are mixed in between accesses. Wait-state counts, data and error flags are compared against a bench model of the registers and the queue, which tells latency faults apart from decode or mux faults. Directed cases fill the queue to overflow, send an unprivileged push into a full queue to test the check order, clear the flag with a bit-0 write and with a zero write, and drop select during a wait cycle to show that nothing commits before completion.

// File: rtl/apbw_pkg.sv
package apbw_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DONE = 2'd2
    } apbw_state_e;

    localparam int LAT_W      = 2;
    localparam int NUM_PLAIN  = 3;
    localparam int IDX_FIFO   = 3;
    localparam int IDX_STATUS = 4;
    localparam int REG_COUNT  = 5;
    localparam int CNT_LSB    = 8;

    function automatic logic [LAT_W-1:0] reg_latency(input int unsigned idx);
        logic [LAT_W-1:0] lat;
        case (idx)
            0:       lat = 2'd0;
            1:       lat = 2'd1;
            2:       lat = 2'd2;
            3:       lat = 2'd3;
            4:       lat = 2'd1;
            default: lat = 2'd0;
        endcase
        return lat;
    endfunction

    function automatic logic reg_needs_priv(input int unsigned idx);
        return (idx == 2) || (idx == IDX_FIFO);
    endfunction
endpackage

// File: rtl/apbw_decode.sv
module apbw_decode
    import apbw_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             priv,
    output logic             early_err,
    output logic [LAT_W-1:0] lat
);
    timeunit 1ns;
    timeprecision 1ps;

    logic mapped;
    logic prot_ok;

    always_comb begin
        mapped    = (32'(idx) < REG_COUNT);
        prot_ok   = !reg_needs_priv(32'(idx)) || priv;
        early_err = !mapped || !prot_ok;
        lat       = early_err ? '0 : reg_latency(32'(idx));
    end
endmodule

// File: rtl/apbw_fifo.sv
module apbw_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [DW-1:0]                wdata,
    input  logic                         pop,
    output logic                         full,
    output logic                         empty,
    output logic [DW-1:0]                head,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] rd_ptr_q, wr_ptr_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr_q];
    assign count   = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (do_push) wr_ptr_q <= bump(wr_ptr_q);
            if (do_pop)  rd_ptr_q <= bump(rd_ptr_q);
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr_q] <= wdata;
    end
endmodule

// File: rtl/apbw_ctrl.sv
module apbw_ctrl
    import apbw_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             psel,
    input  logic             penable,
    input  logic             pwrite,
    input  logic [IDX_W-1:0] idx_in,
    input  logic             early_in,
    input  logic [LAT_W-1:0] lat_in,
    output logic             pready,
    output logic             data_valid,
    output logic [IDX_W-1:0] cur_idx,
    output logic             cur_early,
    output logic             wr_q,
    output logic             load_rd,
    output logic             completion
);
    timeunit 1ns;
    timeprecision 1ps;

    apbw_state_e      state_q, state_nxt;
    logic [IDX_W-1:0] idx_q;
    logic             early_q;
    logic [LAT_W-1:0] cnt_q;
    logic             valid_q;
    logic             setup;

    assign setup = psel && !penable;

    // next-state logic
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE: if (setup) state_nxt = (lat_in == '0) ? ST_DONE : ST_WAIT;
            ST_WAIT: begin
                if (!psel)                     state_nxt = ST_IDLE;
                else if (cnt_q == LAT_W'(1))   state_nxt = ST_DONE;
            end
            ST_DONE: state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nxt;
    end

    // registered outputs and captured access fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            early_q <= 1'b0;
            wr_q    <= 1'b0;
            cnt_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= (state_nxt == ST_DONE);
            if (state_q == ST_IDLE && setup) begin
                idx_q   <= idx_in;
                early_q <= early_in;
                wr_q    <= pwrite;
                cnt_q   <= lat_in;
            end else if (state_q == ST_WAIT) begin
                cnt_q   <= cnt_q - LAT_W'(1);
            end
        end
    end

    assign cur_idx    = (state_q == ST_IDLE) ? idx_in   : idx_q;
    assign cur_early  = (state_q == ST_IDLE) ? early_in : early_q;
    assign load_rd    = (state_nxt == ST_DONE) &&
                        !((state_q == ST_IDLE) ? pwrite : wr_q);
    assign data_valid = valid_q;
    assign pready     = (state_q == ST_IDLE) || valid_q;
    assign completion = valid_q && psel && penable;
endmodule

// File: rtl/apbw_slave.sv
module apbw_slave
    import apbw_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic [2:0]        pprot,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              drain_pop,
    output logic              drain_valid,
    output logic [DATA_W-1:0] drain_data
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int IDX_W = ADDR_W - 2;
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    logic [IDX_W-1:0]  live_idx, cur_idx;
    logic              live_early, cur_early;
    logic [LAT_W-1:0]  live_lat;
    logic              data_valid, wr_q, load_rd, completion;
    logic              fifo_full, fifo_empty;
    logic [CNT_W-1:0]  fifo_cnt;
    logic              is_fifo, is_stat, overflow_c, err_c, commit;
    logic              ovf_q;
    logic [DATA_W-1:0] scratch [NUM_PLAIN];
    logic [DATA_W-1:0] rd_val, rdata_q;
    logic              unused_bits;

    assign live_idx    = paddr[ADDR_W-1:2];
    assign unused_bits = ^{paddr[1:0], pprot[2:1]};

    apbw_decode #(.IDX_W(IDX_W)) u_decode (
        .idx       (live_idx),
        .priv      (pprot[0]),
        .early_err (live_early),
        .lat       (live_lat)
    );

    apbw_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .psel       (psel),
        .penable    (penable),
        .pwrite     (pwrite),
        .idx_in     (live_idx),
        .early_in   (live_early),
        .lat_in     (live_lat),
        .pready     (pready),
        .data_valid (data_valid),
        .cur_idx    (cur_idx),
        .cur_early  (cur_early),
        .wr_q       (wr_q),
        .load_rd    (load_rd),
        .completion (completion)
    );

    // error ordering: decode/privilege captured at setup, then overflow
    assign is_fifo    = (cur_idx == IDX_W'(IDX_FIFO));
    assign is_stat    = (cur_idx == IDX_W'(IDX_STATUS));
    assign overflow_c = wr_q && !cur_early && is_fifo && fifo_full;
    assign err_c      = cur_early || overflow_c;
    assign pslverr    = completion && err_c;
    assign commit     = completion && wr_q && !err_c;

    apbw_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (commit && is_fifo),
        .wdata (pwdata),
        .pop   (drain_pop),
        .full  (fifo_full),
        .empty (fifo_empty),
        .head  (drain_data),
        .count (fifo_cnt)
    );

    assign drain_valid = !fifo_empty;

    generate
        for (genvar g = 0; g < NUM_PLAIN; g++) begin : g_plain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                               scratch[g] <= '0;
                else if (commit && cur_idx == IDX_W'(g))  scratch[g] <= pwdata;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                ovf_q <= 1'b0;
        else if (completion && overflow_c)         ovf_q <= 1'b1;
        else if (commit && is_stat && pwdata[0])   ovf_q <= 1'b0;
    end

    always_comb begin
        rd_val = '0;
        if (!cur_early) begin
            if (32'(cur_idx) < NUM_PLAIN) rd_val = scratch[cur_idx[1:0]];
            else if (is_fifo)             rd_val = DATA_W'(fifo_cnt);
            else if (is_stat)             rd_val = (DATA_W'(fifo_cnt) << CNT_LSB) | DATA_W'(ovf_q);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rdata_q <= '0;
        else if (load_rd) rdata_q <= rd_val;
    end

    assign prdata = (data_valid && !wr_q) ? rdata_q : '0;
endmodule

// File: rtl/apbw_checker.sv
module apbw_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              penable,
    input logic              pready,
    input logic              pslverr,
    input logic [DATA_W-1:0] prdata,
    input logic              commit
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [2:0] stall_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          stall_q <= '0;
        else if (psel && penable && !pready) stall_q <= (stall_q == 3'd7) ? stall_q : stall_q + 3'd1;
        else                                 stall_q <= '0;
    end

    AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (!psel && !$past(psel)) |-> pready); // R1
    AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        stall_q <= 3'd3); // R2
    AST_PRDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && !pready) |-> (prdata == '0)); // R3
    AST_COMMIT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (psel && penable && pready)); // R4
    AST_ERR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        pslverr |-> (psel && penable && pready)); // R10
    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pslverr |=> !pslverr); // R10
endmodule

bind apbw_slave apbw_checker #(.DATA_W(DATA_W)) u_apbw_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .psel    (psel),
    .penable (penable),
    .pready  (pready),
    .pslverr (pslverr),
    .prdata  (prdata),
    .commit  (commit)
);

// File: tb/test_apbw_slave.sv
module test_apbw_slave;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int AW = 8;
    localparam int DW = 32;
    localparam int DEPTH = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [AW-1:0] paddr = '0;
    logic [DW-1:0] pwdata = '0;
    logic [2:0]    pprot = '0;
    logic [DW-1:0] prdata;
    logic          pready, pslverr;
    logic          drain_pop = 1'b0;
    logic          drain_valid;
    logic [DW-1:0] drain_data;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [DW-1:0] m_reg [3];
    logic [DW-1:0] m_q [$];
    bit            m_ovf;

    always #4 clk = ~clk;

    apbw_slave #(.ADDR_W(AW), .DATA_W(DW), .FIFO_DEPTH(DEPTH)) i_apbw_slave (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .pprot(pprot), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .drain_pop(drain_pop),
        .drain_valid(drain_valid), .drain_data(drain_data)
    );

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_lat(input int idx);
        case (idx)
            0: return 0;
            1: return 1;
            2: return 2;
            3: return 3;
            4: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic bit exp_early(input int idx, input logic [2:0] pr);
        return (idx > 4) || (((idx == 2) || (idx == 3)) && !pr[0]);
    endfunction

    function automatic logic [DW-1:0] exp_read(input int idx);
        case (idx)
            0, 1, 2: return m_reg[idx];
            3: return DW'(m_q.size());
            4: return (DW'(m_q.size()) << 8) | DW'(m_ovf);
            default: return '0;
        endcase
    endfunction

    task automatic xfer(input logic [AW-1:0] a, input bit w, input logic [DW-1:0] d,
                        input logic [2:0] pr, output logic [DW-1:0] rd, output bit er, output int nw);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; paddr = a; pwrite = w; pwdata = d; pprot = pr;
        @(negedge clk);
        penable = 1'b1;
        nw = 0;
        #1;
        while (!pready && nw < 20) begin
            chk(pslverr == 1'b0, "R10 wait-cycle pslverr", DW'(pslverr), 0);
            chk(prdata == '0, "R3 wait-cycle prdata", prdata, 0);
            nw++;
            @(negedge clk);
            #1;
        end
        rd = prdata;
        er = pslverr;
        @(posedge clk);
        #1;
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic op(input int idx, input bit w, input logic [DW-1:0] d, input logic [2:0] pr, input string tag);
        logic [DW-1:0] rd, erd;
        bit er, early, ovf, eerr;
        int nw;
        logic [AW-1:0] a;
        a = AW'(idx << 2) | AW'($urandom_range(0, 3));
        early = exp_early(idx, pr);
        ovf = !early && w && idx == 3 && m_q.size() == DEPTH;
        eerr = early || ovf;
        erd = (w || early) ? '0 : exp_read(idx);
        xfer(a, w, d, pr, rd, er, nw);
        chk(nw == (early ? 0 : exp_lat(idx)), {"R2 waits ", tag}, DW'(nw), DW'(early ? 0 : exp_lat(idx)));
        chk(er == eerr, {"R5/R6/R8 pslverr ", tag}, DW'(er), DW'(eerr));
        chk(rd == erd, {"R3/R7/R9/R11 prdata ", tag}, rd, erd);
        if (w && !eerr) begin
            if (idx < 3) m_reg[idx] = d;
            else if (idx == 3) m_q.push_back(d);
            else if (idx == 4 && d[0]) m_ovf = 1'b0;
        end
        if (ovf) m_ovf = 1'b1;
    endtask

    task automatic pop_one(input string tag);
        @(negedge clk);
        chk(drain_valid == (m_q.size() > 0), {"R7 drain_valid ", tag}, DW'(drain_valid), DW'(m_q.size() > 0));
        if (m_q.size() > 0)
            chk(drain_data == m_q[0], {"R7 drain order ", tag}, drain_data, m_q[0]);
        drain_pop = 1'b1;
        @(negedge clk);
        drain_pop = 1'b0;
        if (m_q.size() > 0) void'(m_q.pop_front());
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired checks=%0d", checks);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        end
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        foreach (m_reg[i]) m_reg[i] = '0;
        m_ovf = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(pready == 1'b1, "R1 reset pready", DW'(pready), 1);
        chk(pslverr == 1'b0, "R1 reset pslverr", DW'(pslverr), 0);
        chk(prdata == '0, "R1 reset prdata", prdata, 0);
        chk(drain_valid == 1'b0, "R1 reset drain_valid", DW'(drain_valid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(pready == 1'b1, "R1 idle pready", DW'(pready), 1);

        // R11 reset values and plain read/write
        for (int i = 0; i < 3; i++) op(i, 0, '0, 3'b001, "R11 reset value");
        op(0, 1, 32'hA5A5_0001, 3'b000, "R11 write0");
        op(1, 1, 32'h1234_5678, 3'b000, "R11 write1");
        op(2, 1, 32'hCAFE_F00D, 3'b001, "R11 write2 priv");
        for (int i = 0; i < 3; i++) op(i, 0, '0, 3'b001, "R11 readback");

        // R5 unmapped
        op(7, 1, 32'hDEAD_BEEF, 3'b001, "R5 unmapped write");
        op(5, 0, '0, 3'b001, "R5 unmapped read");
        op(0, 0, '0, 3'b000, "R5 no side effect");

        // R6 privilege
        op(2, 1, 32'h0BAD_0BAD, 3'b110, "R6 unpriv write");
        op(2, 0, '0, 3'b001, "R6 key unchanged");
        op(3, 1, 32'h1, 3'b000, "R6 unpriv push");
        op(3, 0, '0, 3'b001, "R6 count unchanged");

        // R4 abandoned write during wait cycle (index 1, one wait)
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; paddr = AW'(1 << 2); pwrite = 1'b1; pwdata = 32'h7777_7777; pprot = 3'b000;
        @(negedge clk);
        penable = 1'b1;
        #1;
        chk(pready == 1'b0, "R4 abort wait seen", DW'(pready), 0);
        #1;
        psel = 1'b0; penable = 1'b0;
        repeat (2) @(negedge clk);
        chk(pready == 1'b1, "R1 after abort", DW'(pready), 1);
        op(1, 0, '0, 3'b000, "R4 abort no commit");

        // R8 overflow and R6 ordering
        for (int i = 0; i < DEPTH; i++) op(3, 1, 32'h100 + i, 3'b001, "R7 push");
        op(3, 0, '0, 3'b001, "R7 count full");
        op(3, 1, 32'hFFFF_0000, 3'b001, "R8 overflow push");
        op(4, 0, '0, 3'b000, "R8 sticky set");
        op(4, 1, 32'h0, 3'b000, "R9 write zero");
        op(4, 0, '0, 3'b000, "R9 still set");
        op(4, 1, 32'h1, 3'b000, "R9 clear");
        op(4, 0, '0, 3'b000, "R9 cleared");
        op(3, 1, 32'h5555, 3'b000, "R6 order unpriv full");
        op(4, 0, '0, 3'b000, "R6 order no sticky");

        // R7 drain order
        for (int i = 0; i < DEPTH + 1; i++) pop_one("directed");
        op(4, 0, '0, 3'b000, "R9 empty status");

        // random traffic
        for (int n = 0; n < 400; n++) begin
            int idx;
            bit w;
            idx = $urandom_range(0, 7);
            w = $urandom_range(0, 1) == 1;
            op(idx, w, $urandom, 3'($urandom_range(0, 7)), "random");
            if ($urandom_range(0, 3) == 0) pop_one("random");
        end

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
        end
        $finish;
    end
endmodule